// File: doc/BRIEF.md
# Interrupt-Driven Bus Priority Elevation

This block raises a high-priority request toward the system bus arbiter for as long as the processor is servicing an interrupt. It handles two classes of interrupt. Critical interrupts reach the core directly from outside the platform. External interrupts reach it through the interrupt controller.

Each class has two gates. The first is a servicing-enable flag taken from the core's machine state. The second is a configuration bit that permits elevation for that class. A detection counts only when both gates of its class are set. The detection sets a per-class active flag. That flag stays set until the return instruction that belongs to its class is seen. The output is the OR of the two flags. A critical interrupt nested inside external servicing therefore cannot drop elevation early.

Top module: `irq_bus_boost`

## Requirements
- R1: A synchronous active-high `rst` clears both class flags. `hi_prio` reads 0 after any clock edge at which `rst` is 1, whatever the other inputs are.
- R2: `crit_irq` sets the critical flag, and drives `hi_prio` to 1 at the next clock edge, only when `crit_en` and `crit_boost_cfg` are both 1. With either of them at 0, a `crit_irq` pulse leaves `hi_prio` at 0.
- R3: Once set, the critical flag holds across idle cycles and across `ext_ret` pulses. It clears at the edge where `crit_ret` is 1.
- R4: `ext_irq` sets the external flag, and drives `hi_prio` to 1 at the next clock edge, only when `ext_en` and `ext_boost_cfg` are both 1. With either of them at 0, an `ext_irq` pulse leaves `hi_prio` at 0.
- R5: Once set, the external flag holds across idle cycles and across `crit_ret` pulses. It clears at the edge where `ext_ret` is 1.
- R6: `hi_prio` is the OR of the two flags. If a critical interrupt nests inside external servicing, `crit_ret` leaves `hi_prio` at 1 until `ext_ret` is seen.
- R7: A return pulse for a class whose flag is clear has no effect. The other class's flag is unchanged, and `hi_prio` stays as it was.
- R8: If a qualified detection and the return pulse of the same class arrive in one cycle, the flag is set (or stays set) after that edge.
- R9: A class's flag clears at the next edge whenever its configuration bit (`crit_boost_cfg` or `ext_boost_cfg`) is 0, even if the flag was set.
- R10: `hi_prio` never rises unless a qualified detection of some class was present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_irq | input | 1 | Critical interrupt detected |
| crit_en | input | 1 | Critical interrupt servicing enabled |
| crit_boost_cfg | input | 1 | Elevation allowed for critical interrupts |
| crit_ret | input | 1 | Return-from-critical-interrupt pulse |
| ext_irq | input | 1 | External interrupt detected (from interrupt controller) |
| ext_en | input | 1 | External interrupt servicing enabled |
| ext_boost_cfg | input | 1 | Elevation allowed for external interrupts |
| ext_ret | input | 1 | Return-from-interrupt pulse |
| hi_prio | output | 1 | Bus high-priority request |

## Verification
Directed sequences try each gate on its own: a detection with only the servicing enable, then with only the configuration bit. This shows whether the two gates are really ANDed. Cross-class return pulses and nested critical-within-external servicing show whether the flags are independent and the output is their OR. Same-cycle detection and return, and a configuration drop while a flag is set, pin down the priority order of set, clear and disable. A long seeded random stream with occasional resets is then compared against a bench model of the two flags, which exposes any wrong combination of these rules.

// File: rtl/irq_bus_boost.sv
module irq_bus_boost (
  input  logic clk,
  input  logic rst,
  input  logic crit_irq,
  input  logic crit_en,
  input  logic crit_boost_cfg,
  input  logic crit_ret,
  input  logic ext_irq,
  input  logic ext_en,
  input  logic ext_boost_cfg,
  input  logic ext_ret,
  output logic hi_prio
);

  logic crit_act, ext_act;
  logic crit_hit, ext_hit;

  assign crit_hit = crit_irq & crit_en;
  assign ext_hit  = ext_irq & ext_en;

  always_ff @(posedge clk) begin
    if (rst || !crit_boost_cfg) crit_act <= 1'b0;
    else if (crit_hit)          crit_act <= 1'b1;
    else if (crit_ret)          crit_act <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !ext_boost_cfg) ext_act <= 1'b0;
    else if (ext_hit)          ext_act <= 1'b1;
    else if (ext_ret)          ext_act <= 1'b0;
  end

  assign hi_prio = crit_act | ext_act;

endmodule

module irq_bus_boost_chk (
  input logic clk,
  input logic rst,
  input logic crit_irq,
  input logic crit_en,
  input logic crit_boost_cfg,
  input logic crit_ret,
  input logic ext_irq,
  input logic ext_en,
  input logic ext_boost_cfg,
  input logic ext_ret,
  input logic hi_prio
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q == 1'b1) a_r1_reset_clears: assert (!hi_prio);

  a_r2_crit_sets: assert property (@(posedge clk) disable iff (rst)
    crit_irq && crit_en && crit_boost_cfg |=> hi_prio);

  a_r4_ext_sets: assert property (@(posedge clk) disable iff (rst)
    ext_irq && ext_en && ext_boost_cfg |=> hi_prio);

  // R3, R5: no return pulse and both classes allowed -> elevation holds
  a_r5_holds: assert property (@(posedge clk) disable iff (rst)
    hi_prio && !crit_ret && !ext_ret && crit_boost_cfg && ext_boost_cfg |=> hi_prio);

  a_r9_cfg_off: assert property (@(posedge clk) disable iff (rst)
    !crit_boost_cfg && !ext_boost_cfg |=> !hi_prio);

  a_r10_no_spurious_rise: assert property (@(posedge clk) disable iff (rst)
    !hi_prio && !(crit_irq && crit_en && crit_boost_cfg)
             && !(ext_irq && ext_en && ext_boost_cfg) |=> !hi_prio);
endmodule

bind irq_bus_boost irq_bus_boost_chk u_chk (.*);

// File: tb/irq_bus_boost_tb.sv
module irq_bus_boost_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  // vector bits: [8]rst [7]crit_irq [6]crit_en [5]crit_boost_cfg [4]crit_ret
  //              [3]ext_irq [2]ext_en [1]ext_boost_cfg [0]ext_ret
  logic [8:0] v = '0;
  logic hi_prio;

  irq_bus_boost u_dut (
    .clk(clk), .rst(v[8]),
    .crit_irq(v[7]), .crit_en(v[6]), .crit_boost_cfg(v[5]), .crit_ret(v[4]),
    .ext_irq(v[3]), .ext_en(v[2]), .ext_boost_cfg(v[1]), .ext_ret(v[0]),
    .hi_prio(hi_prio));

  localparam logic [8:0] IDLE = 9'b0_0110_0110;
  localparam logic [8:0] RST  = 9'h100;
  localparam logic [8:0] CI   = 9'h080;
  localparam logic [8:0] CE   = 9'h040;
  localparam logic [8:0] CC   = 9'h020;
  localparam logic [8:0] CR   = 9'h010;
  localparam logic [8:0] EI   = 9'h008;
  localparam logic [8:0] EE   = 9'h004;
  localparam logic [8:0] EC   = 9'h002;
  localparam logic [8:0] ER   = 9'h001;

  int checks = 0, fails = 0;
  logic m_crit = 1'b0, m_ext = 1'b0;

  function automatic logic next_flag(logic f, logic r, logic irq, logic en, logic cfg, logic ret);
    if (r || !cfg) return 1'b0;
    if (irq && en) return 1'b1;
    if (ret) return 1'b0;
    return f;
  endfunction

  task automatic step(input logic [8:0] vec, input string tag);
    @(negedge clk);
    v = vec;
    @(posedge clk);
    m_crit = next_flag(m_crit, vec[8], vec[7], vec[6], vec[5], vec[4]);
    m_ext  = next_flag(m_ext,  vec[8], vec[3], vec[2], vec[1], vec[0]);
    #5;
    checks++;
    if (hi_prio !== (m_crit | m_ext)) begin
      fails++;
      $display("FAIL %s: hi_prio=%b expected=%b (vec=%b)", tag, hi_prio, m_crit | m_ext, vec);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    step(RST | IDLE | CI | EI, "R1");
    step(RST, "R1");
    step(IDLE & ~CE | CI, "R2");
    step(IDLE & ~CC | CI, "R2");
    step(IDLE | CI, "R2");
    step(IDLE, "R3");
    step(IDLE | ER, "R3");
    step(IDLE | CR, "R3");
    step(IDLE & ~EE | EI, "R4");
    step(IDLE & ~EC | EI, "R4");
    step(IDLE | EI, "R4");
    step(IDLE, "R5");
    step(IDLE | CR, "R5");
    step(IDLE | ER, "R5");
    step(IDLE | EI, "R6");
    step(IDLE | CI, "R6");
    step(IDLE | CR, "R6");
    step(IDLE | ER, "R6");
    step(IDLE | CR, "R7");
    step(IDLE | ER, "R7");
    step(IDLE | CI, "R7");
    step(IDLE | ER, "R7");
    step(IDLE | CR, "R7");
    step(IDLE | CI | CR, "R8");
    step(IDLE | CI | CR, "R8");
    step(IDLE | CR, "R8");
    step(IDLE | EI | ER, "R8");
    step(IDLE | ER, "R8");
    step(IDLE | CI | EI, "R9");
    step(IDLE & ~CC, "R9");
    step(IDLE & ~EC, "R9");
    step(IDLE & ~EC | EI, "R9");
    step(RST, "R1");
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [8:0] r;
      r = 9'($urandom);
      r[8] = ($urandom_range(63) == 0);
      r[5] = ($urandom_range(7) != 0);
      r[1] = ($urandom_range(7) != 0);
      r[7] = r[7] & ($urandom_range(3) == 0);
      r[3] = r[3] & ($urandom_range(3) == 0);
      r[4] = r[4] & ($urandom_range(3) == 0);
      r[0] = r[0] & ($urandom_range(3) == 0);
      step(r, "R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule